// File: doc/BRIEF.md
# Packed RGB Pixel Unpacker

This block turns a stream of 16-bit host halfwords into 24-bit 8:8:8 RGB pixels for writing into a framebuffer. A 4-bit format code picks how the incoming bytes map onto red, green and blue. Three layouts are supported:

- a 16-bit 5:6:5 word that becomes one pixel;
- a six-byte group that yields two pixels, with the bytes interleaved between the two;
- a four-byte group that yields one pixel and carries one padding byte.

Any other code is flagged as an error, and data presented under it is consumed and dropped.

Both stream edges use valid/ready. A halfword transfers on a rising edge when `in_valid` and `in_ready` are both high. A pixel transfers when `out_valid` and `out_ready` are both high.

While a pixel is waiting and `out_ready` is low, `out_valid` stays high, `out_pixel` holds its value and `in_ready` is low. `in_ready` is also low for the one cycle in which the format code differs from the code the block latched on the previous edge. This lets the unpacking restart cleanly at the first byte of a group. Each halfword is taken low byte first, and a group that is not yet complete is held across halfwords.

Top module: `rgb_unpacker`

## Requirements
- R1: Format code 1 (5:6:5) maps each accepted halfword h to one pixel. Red is h[15:11] followed by three zero bits, green is h[10:5] followed by two zero bits, and blue is h[4:0] followed by three zero bits. `out_pixel` is packed as {red[23:16], green[15:8], blue[7:0]}, and the pixel is presented the cycle after acceptance.
- R2: Format codes 2 and 3 take bytes in the order G0, R0, R1, B0, B1, G1, with each halfword holding the earlier byte in bits 7:0. Every three halfwords produce pixel {R0,G0,B0} after the second halfword and then pixel {R1,G1,B1} after the third.
- R3: Format codes 6 and 7 take bytes in the order R, pad, B, G. Every two halfwords produce one pixel {R,G,B}, presented after the second halfword.
- R4: For any code other than 1, 2, 3, 6 and 7, `fmt_err` is high from the cycle after the code is presented. Halfwords are still accepted, and no pixel is produced.
- R5: In the first cycle a new format code is present, `in_ready` is low. The next halfword accepted is treated as the first of a group, whatever the unpacking phase was before.
- R6: While `out_valid` is high and `out_ready` is low, `out_pixel` and `out_valid` keep their values and `in_ready` is low.
- R7: During and just after reset, `out_valid` and `fmt_err` are low. The latched format code resets to 3.
- R8: With an empty output stage and a stable format code, `in_ready` is high, so one halfword can be accepted every cycle.
- R9: The padding byte of the four-byte layout has no effect on the pixel produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_code | input | 4 | Input format code |
| in_valid | input | 1 | Halfword available |
| in_data | input | 16 | Halfword, earlier byte in bits 7:0 |
| in_ready | output | 1 | Halfword accepted this edge when high together with in_valid |
| out_valid | output | 1 | Pixel available |
| out_pixel | output | 24 | Pixel {R,G,B} |
| out_ready | input | 1 | Consumer takes the pixel |
| fmt_err | output | 1 | Latched format code is unsupported |

## Verification
The bench sweeps all 5:6:5 field patterns, many six- and four-byte groups under both codes of each layout, and every unsupported code. A design that mixed up the interleaved byte order, emitted the two pixels of a group in the wrong order, or let the pad byte reach a pixel would produce wrong pixel values. A block that kept its group phase across a code change would emit a pixel one halfword early after the switch. A block that let an unsupported code through would produce stray pixels. Under back-pressure, a design that overwrote or dropped the held pixel would show a changed `out_pixel` or a missing pixel in the captured stream.

// File: rtl/rgbu_pkg.sv
package rgbu_pkg;
  localparam int BYTE_W = 8;
  localparam int HW_W   = 2 * BYTE_W;
  localparam int PIX_W  = 3 * BYTE_W;
  localparam int FMT_W  = 4;
  localparam int PH_W   = 2;

  typedef enum logic [1:0] {
    UM_NONE = 2'd0,
    UM_565  = 2'd1,
    UM_3B   = 2'd2,
    UM_4B   = 2'd3
  } unpack_mode_e;

  function automatic unpack_mode_e fmt_to_mode(input logic [FMT_W-1:0] code);
    unpack_mode_e m;
    case (code)
      4'd1:       m = UM_565;
      4'd2, 4'd3: m = UM_3B;
      4'd6, 4'd7: m = UM_4B;
      default:    m = UM_NONE;
    endcase
    return m;
  endfunction

  function automatic logic [PIX_W-1:0] widen_565(input logic [HW_W-1:0] h);
    logic [BYTE_W-1:0] r, g, b;
    r = {h[15:11], 3'b000};
    g = {h[10:5], 2'b00};
    b = {h[4:0], 3'b000};
    return {r, g, b};
  endfunction
endpackage

// File: rtl/rgbu_fmt_track.sv
module rgbu_fmt_track
  import rgbu_pkg::*;
#(
  parameter logic [FMT_W-1:0] RESET_FMT = 4'd3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FMT_W-1:0] code_in,
  output unpack_mode_e     mode,
  output logic             code_moved,
  output logic             bad_code
);
  logic [FMT_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) code_q <= RESET_FMT;
    else        code_q <= code_in;
  end

  always_comb begin
    mode       = fmt_to_mode(code_q);
    code_moved = (code_in != code_q);
    bad_code   = (mode == UM_NONE);
  end
endmodule

// File: rtl/rgbu_group_asm.sv
module rgbu_group_asm
  import rgbu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              take,
  input  logic [HW_W-1:0]   hw,
  input  unpack_mode_e      mode,
  output logic              pix_fire,
  output logic [PIX_W-1:0]  pix
);
  logic [PH_W-1:0]   phase, phase_nxt;
  logic [HW_W-1:0]   first_hw;
  logic [BYTE_W-1:0] spare_byte;

  always_comb begin
    pix_fire  = 1'b0;
    pix       = '0;
    phase_nxt = phase;
    case (mode)
      UM_565: begin
        pix_fire  = take;
        pix       = widen_565(hw);
        phase_nxt = '0;
      end
      UM_3B: begin
        case (phase)
          2'd0: phase_nxt = 2'd1;
          2'd1: begin
            pix_fire  = take;
            pix       = {first_hw[15:8], first_hw[7:0], hw[15:8]};
            phase_nxt = 2'd2;
          end
          default: begin
            pix_fire  = take;
            pix       = {spare_byte, hw[15:8], hw[7:0]};
            phase_nxt = 2'd0;
          end
        endcase
      end
      UM_4B: begin
        if (phase == 2'd0) begin
          phase_nxt = 2'd1;
        end else begin
          pix_fire  = take;
          pix       = {first_hw[7:0], hw[15:8], hw[7:0]};
          phase_nxt = 2'd0;
        end
      end
      default: phase_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      phase <= '0;
    end else if (take) begin
      phase <= phase_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_hw   <= '0;
      spare_byte <= '0;
    end else if (take) begin
      if (phase == 2'd0) first_hw <= hw;
      if (phase == 2'd1) spare_byte <= hw[7:0];
    end
  end
endmodule

// File: rtl/rgbu_out_stage.sv
module rgbu_out_stage
  import rgbu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PIX_W-1:0] load_pix,
  input  logic             sink_ready,
  output logic             can_accept,
  output logic             valid_q,
  output logic [PIX_W-1:0] pix_q
);
  assign can_accept = !valid_q || sink_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pix_q   <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      pix_q   <= load_pix;
    end else if (sink_ready) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rgb_unpacker.sv
module rgb_unpacker
  import rgbu_pkg::*;
#(
  parameter logic [FMT_W-1:0] RESET_FMT = 4'd3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FMT_W-1:0] fmt_code,
  input  logic             in_valid,
  input  logic [HW_W-1:0]  in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pixel,
  input  logic             out_ready,
  output logic             fmt_err
);
  unpack_mode_e     mode;
  logic             code_moved;
  logic             can_accept;
  logic             take;
  logic             pix_fire;
  logic [PIX_W-1:0] pix;

  rgbu_fmt_track #(.RESET_FMT(RESET_FMT)) u_fmt (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_in    (fmt_code),
    .mode       (mode),
    .code_moved (code_moved),
    .bad_code   (fmt_err)
  );

  assign in_ready = !code_moved && can_accept;
  assign take     = in_valid && in_ready;

  rgbu_group_asm u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (code_moved),
    .take     (take),
    .hw       (in_data),
    .mode     (mode),
    .pix_fire (pix_fire),
    .pix      (pix)
  );

  rgbu_out_stage u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (pix_fire),
    .load_pix   (pix),
    .sink_ready (out_ready),
    .can_accept (can_accept),
    .valid_q    (out_valid),
    .pix_q      (out_pixel)
  );
endmodule

// File: rtl/rgbu_checker.sv
module rgbu_checker
  import rgbu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [FMT_W-1:0] fmt_code,
  input logic             in_valid,
  input logic [HW_W-1:0]  in_data,
  input logic             in_ready,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_pixel,
  input logic             out_ready,
  input logic             fmt_err
);
  function automatic logic [PIX_W-1:0] ref565(input logic [HW_W-1:0] h);
    return {h[15:11], 3'b000, h[10:5], 2'b00, h[4:0], 3'b000};
  endfunction

  a_r1_expand565: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && fmt_code == 4'd1) |=>
      (out_valid && out_pixel == ref565($past(in_data))));

  a_r4_no_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_err && in_valid && in_ready && !out_valid) |=> !out_valid);

  a_r5_change_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && fmt_code != $past(fmt_code)) |-> !in_ready);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel)));

  a_r6_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r8_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !out_valid && fmt_code == $past(fmt_code)) |-> in_ready);
endmodule

bind rgb_unpacker rgbu_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fmt_code  (fmt_code),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_pixel (out_pixel),
  .out_ready (out_ready),
  .fmt_err   (fmt_err)
);

// File: tb/sim_rgb_unpacker.sv
module sim_rgb_unpacker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  fmt_code = 4'd3;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [23:0] out_pixel;
  logic        out_ready = 1'b1;
  logic        fmt_err;

  int total = 0;
  int bad = 0;
  logic [23:0] exp_q[$];
  logic [23:0] got_q[$];

  always #2 clk = ~clk;

  rgb_unpacker u0 (
    .clk(clk), .rst_n(rst_n), .fmt_code(fmt_code), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_pixel(out_pixel), .out_ready(out_ready), .fmt_err(fmt_err)
  );

  always begin
    @(negedge clk);
    #1;
    if (rst_n && out_valid && out_ready) got_q.push_back(out_pixel);
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic push_hw(input logic [15:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic set_fmt(input logic [3:0] c);
    @(negedge clk);
    fmt_code = c;
    @(negedge clk);
  endtask

  task automatic compare(input string req);
    repeat (4) @(negedge clk);
    check(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], req, {8'h0, got_q[i]}, {8'h0, exp_q[i]});
    got_q.delete();
    exp_q.delete();
  endtask

  function automatic logic [7:0] bval(input int n);
    return 8'((n * 37 + 11) ^ (n >> 3));
  endfunction

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R7 out_valid in reset", out_valid, 0);
    check(fmt_err == 1'b0, "R7 fmt_err in reset", fmt_err, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R7 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R8 ready after reset", in_ready, 1);

    // R1: 5:6:5 sweep
    set_fmt(4'd1);
    for (int i = 0; i < 258; i++) begin
      logic [15:0] h;
      h = (i == 256) ? 16'hFFFF : (i == 257) ? 16'h0000 : {i[7:0], i[7:0] ^ 8'h5A};
      exp_q.push_back({h[15:11], 3'b0, h[10:5], 2'b0, h[4:0], 3'b0});
      push_hw(h);
    end
    compare("R1 565 expansion");

    // R2: six-byte groups, codes 2 and 3
    for (int c = 2; c <= 3; c++) begin
      set_fmt(4'(c));
      for (int g = 0; g < 40; g++) begin
        logic [7:0] b [6];
        for (int k = 0; k < 6; k++) b[k] = bval(g * 6 + k + c * 500);
        // order G0 R0 R1 B0 B1 G1
        exp_q.push_back({b[1], b[0], b[3]});
        exp_q.push_back({b[2], b[5], b[4]});
        push_hw({b[1], b[0]});
        push_hw({b[3], b[2]});
        push_hw({b[5], b[4]});
      end
      compare("R2 six-byte order");
    end

    // R3, R9: four-byte groups, codes 6 and 7, pad varied
    for (int c = 6; c <= 7; c++) begin
      set_fmt(4'(c));
      for (int g = 0; g < 40; g++) begin
        logic [7:0] r, p, bb, gg;
        r = bval(g * 4 + c * 300); p = bval(g * 4 + 1 + c * 300);
        bb = bval(g * 4 + 2 + c * 300); gg = bval(g * 4 + 3 + c * 300);
        exp_q.push_back({r, gg, bb});
        push_hw({p, r});
        push_hw({gg, bb});
      end
      compare("R3 four-byte order");
      exp_q.push_back(24'h12_34_56);
      exp_q.push_back(24'h12_34_56);
      push_hw({8'h00, 8'h12}); push_hw({8'h34, 8'h56});
      push_hw({8'hFF, 8'h12}); push_hw({8'h34, 8'h56});
      compare("R9 pad ignored");
    end

    // R4: unsupported codes
    for (int c = 0; c < 16; c++) begin
      if (c == 1 || c == 2 || c == 3 || c == 6 || c == 7) continue;
      set_fmt(4'(c));
      #1;
      check(fmt_err == 1'b1, "R4 fmt_err raised", fmt_err, 1);
      for (int k = 0; k < 4; k++) push_hw(16'hA5C3 + 16'(k));
      compare("R4 no pixel on bad code");
    end

    // R5: change mid-group restarts phase
    set_fmt(4'd2);
    push_hw(16'h1111);
    @(negedge clk);
    fmt_code = 4'd6;
    in_valid = 1'b1;
    #1;
    check(in_ready == 1'b0, "R5 ready low on change", in_ready, 0);
    in_valid = 1'b0;
    push_hw({8'h99, 8'hAB});
    repeat (3) @(negedge clk);
    check(got_q.size() == 0, "R5 no early pixel", got_q.size(), 0);
    exp_q.push_back({8'hAB, 8'hCD, 8'hEF});
    push_hw({8'hCD, 8'hEF});
    compare("R5 restart at group start");
    set_fmt(4'd3);
    push_hw(16'h2222);
    set_fmt(4'd2);
    exp_q.push_back({8'h02, 8'h01, 8'h04});
    push_hw({8'h02, 8'h01}); push_hw({8'h04, 8'h03}); push_hw({8'h06, 8'h05});
    exp_q.push_back({8'h03, 8'h06, 8'h05});
    compare("R5 restart between codes 3 and 2");

    // R6: back-pressure
    set_fmt(4'd1);
    @(negedge clk);
    out_ready = 1'b0;
    push_hw(16'hF81F);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      #1;
      check(out_valid == 1'b1, "R6 valid held", out_valid, 1);
      check(out_pixel == 24'hF800F8, "R6 pixel held", {8'h0, out_pixel}, 32'hF800F8);
      check(in_ready == 1'b0, "R6 input stalled", in_ready, 0);
    end
    @(negedge clk);
    out_ready = 1'b1;
    exp_q.push_back(24'hF800F8);
    compare("R6 held pixel delivered once");
    @(negedge clk);
    #1;
    check(in_ready == 1'b1, "R8 ready when drained", in_ready, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule